// File: doc/BRIEF.md
# Move-Only Transport-Triggered Processor

This block is a 16-bit processor with a single instruction: copy one register to another. A 16-bit instruction word holds a destination register number in its upper byte and a source register number in its lower byte. Sixty-four register addresses make up the whole machine. Most of them are plain storage, holding the program, constants and variables. A handful are functional units. Moving data into a unit's input register feeds it, and reading the unit's output register returns the result. Arithmetic, masking, conditional choice, display output and control flow all happen as side effects of moves.

The sequencer runs three named states in a fixed ring. In FETCH_ST it reads the instruction word from the register addressed by the program counter and advances the counter. In READ_ST it captures the source register value, which may be a unit output. In WRITE_ST it stores that value into the destination and applies the destination's side effect. The transitions are FETCH_ST to READ_ST, READ_ST to WRITE_ST, and WRITE_ST to FETCH_ST, with no other arcs. A move into the program counter arms a pending branch. The next FETCH_ST still takes the sequential word, which is the delay slot, and then loads the target.

After reset the register file holds a built-in image: a self-test program that uses every unit, its constants, and branch targets. The display port presents each value written to register 0 and pulses a strobe, and the program counter is visible for debug.

Top module: `ttm_core`

## Requirements
- R1: While reset is held, disp_o is 0x0000, disp_we_o is 0 and pc_o is 1. The storage is reloaded from the built-in image, and execution starts at register 1.
- R2: Every instruction takes exactly three clock cycles. The destination is taken from bits 13:8 of the instruction and the source from bits 5:0. Bits 15:14 and 7:6 are ignored.
- R3: A move into register 0 puts the value on disp_o and raises disp_we_o for exactly one cycle, in the cycle after the write.
- R4: Registers 60 and 61 are the adder inputs. Reading register 61 returns their 16-bit ones' complement sum, in which a carry out of bit 15 is added back into bit 0. Moving 61 into 61 accumulates.
- R5: A sum that is all ones (minus zero) is returned as 0xFFFF and is not converted to 0x0000.
- R6: Register 53 holds a value and register 54 holds a mask. Reading register 54 returns the value ANDed with the inverse of the mask.
- R7: Reading register 56 returns the content of register 57 if the last value written to 56 was 0x0000. Otherwise it returns the content of register 55.
- R8: A move into register 63 branches to the moved value's low 6 bits after exactly one delay slot. The instruction that follows the delay slot does not execute.
- R9: Without a branch, the counter steps by one per instruction. Reading register 63 returns the address of the instruction after the current one.
- R10: Ordinary registers keep what is written to them and return it when read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_o | output | 16 | Last value moved into register 0 |
| disp_we_o | output | 1 | One-cycle strobe marking a new display value |
| pc_o | output | 6 | Program counter, for debug |

## Verification
The built-in program sends the result of each unit test to the display, so a wrong internal value reaches disp_o within a few instructions of its cause. Each instruction costs three cycles. Faults have these visible effects:
- An adder carry fault or a normalised minus zero shows as a wrong display word.
- A broken selector or a missing delay slot shows as a missing or extra display write, and one marked value must never appear.
- A fault in the counter shows as a changed spacing between strobes, or as pc_o leaving the two-address idle loop at the end of the program.

// File: rtl/ttm_pkg.sv
package ttm_pkg;
    localparam int DW   = 16;
    localparam int AW   = 6;
    localparam int NREG = 1 << AW;

    localparam logic [AW-1:0] A_DISP  = 6'd0;
    localparam logic [AW-1:0] A_START = 6'd1;
    localparam logic [AW-1:0] A_ANDV  = 6'd53;
    localparam logic [AW-1:0] A_ANDM  = 6'd54;
    localparam logic [AW-1:0] A_SELNZ = 6'd55;
    localparam logic [AW-1:0] A_SELC  = 6'd56;
    localparam logic [AW-1:0] A_SELZ  = 6'd57;
    localparam logic [AW-1:0] A_ADDA  = 6'd60;
    localparam logic [AW-1:0] A_ADDB  = 6'd61;
    localparam logic [AW-1:0] A_PC    = 6'd63;

    typedef enum logic [1:0] {FETCH_ST, READ_ST, WRITE_ST} phase_t;

    function automatic logic is_unit(input logic [AW-1:0] a);
        return (a == A_DISP) || (a == A_ANDV) || (a == A_ANDM) ||
               (a == A_SELNZ) || (a == A_SELC) || (a == A_SELZ) ||
               (a == A_ADDA) || (a == A_ADDB) || (a == A_PC);
    endfunction

    function automatic logic [DW-1:0] mv(input logic [7:0] d, input logic [7:0] s);
        return {d, s};
    endfunction

    // Built-in self-test image: program, constants and branch targets
    function automatic logic [DW-1:0] boot_word(input logic [AW-1:0] a);
        unique case (a)
            6'd1:  return mv(8'd60, 8'd40);
            6'd2:  return mv(8'd61, 8'd41);
            6'd3:  return mv(8'd0,  8'd61);
            6'd4:  return mv(8'd61, 8'd42);
            6'd5:  return mv(8'd60, 8'd43);
            6'd6:  return mv(8'd0,  8'd61);
            6'd7:  return mv(8'd61, 8'd61);
            6'd8:  return mv(8'd0,  8'd61);
            6'd9:  return mv(8'd54, 8'd44);
            6'd10: return mv(8'd53, 8'd45);
            6'd11: return mv(8'd0,  8'd54);
            6'd12: return mv(8'd57, 8'd46);
            6'd13: return mv(8'd55, 8'd47);
            6'd14: return mv(8'd56, 8'd48);
            6'd15: return mv(8'd63, 8'd56);
            6'd16: return mv(8'd0,  8'd50);
            6'd17: return mv(8'd0,  8'd51);
            6'd18: return mv(8'd0,  8'd51);
            6'd20: return mv(8'd56, 8'd49);
            6'd21: return mv(8'd63, 8'd56);
            6'd22: return mv(8'd0,  8'd40);
            6'd23: return mv(8'd0,  8'd51);
            6'd24: return mv(8'd0,  8'd63);
            6'd25: return mv(8'd33, 8'd49);
            6'd26: return mv(8'hC0, 8'h61);
            6'd27: return mv(8'd63, 8'd52);
            6'd28: return mv(8'd0,  8'd42);
            6'd29: return mv(8'd0,  8'd51);
            6'd30: return mv(8'd63, 8'd52);
            6'd31: return mv(8'd35, 8'd35);
            6'd40: return 16'h0005;
            6'd41: return 16'hFFFA;
            6'd42: return 16'h0007;
            6'd43: return 16'hFFFD;
            6'd44: return 16'h7FFF;
            6'd45: return 16'h8123;
            6'd46: return 16'd20;
            6'd47: return 16'd24;
            6'd48: return 16'h0000;
            6'd49: return 16'h1234;
            6'd50: return 16'h0063;
            6'd51: return 16'h0077;
            6'd52: return 16'd30;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/ttm_regfile.sv
module ttm_regfile
    import ttm_pkg::*;
#(
    parameter int W = DW,
    parameter int A = AW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [A-1:0] wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic [A-1:0] rd_addr,
    output logic [W-1:0] rd_data
);
    localparam int N = 1 << A;

    logic [W-1:0] mem [N];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) mem[i] <= boot_word(AW'(i));
        end else if (wr_en && !is_unit(wr_addr)) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/ttm_units.sv
module ttm_units
    import ttm_pkg::*;
#(
    parameter int W = DW,
    parameter int A = AW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [A-1:0] wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic [A-1:0] rd_addr,
    output logic [W-1:0] rd_data,
    output logic [W-1:0] disp,
    output logic         disp_we
);
    logic [W-1:0] add_a, add_b, and_v, and_m, sel_nz, sel_c, sel_z;
    logic [W:0]   raw_sum;
    logic [W-1:0] oc_sum;

    // End-around carry; an all-ones result stays all ones
    assign raw_sum = {1'b0, add_a} + {1'b0, add_b};
    assign oc_sum  = raw_sum[W-1:0] + {{(W-1){1'b0}}, raw_sum[W]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            add_a <= '0; add_b <= '0; and_v <= '0; and_m <= '0;
            sel_nz <= '0; sel_c <= '0; sel_z <= '0;
            disp <= '0; disp_we <= 1'b0;
        end else begin
            disp_we <= 1'b0;
            if (wr_en) begin
                unique case (wr_addr)
                    A_DISP:  begin disp <= wr_data; disp_we <= 1'b1; end
                    A_ANDV:  and_v  <= wr_data;
                    A_ANDM:  and_m  <= wr_data;
                    A_SELNZ: sel_nz <= wr_data;
                    A_SELC:  sel_c  <= wr_data;
                    A_SELZ:  sel_z  <= wr_data;
                    A_ADDA:  add_a  <= wr_data;
                    A_ADDB:  add_b  <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (rd_addr)
            A_DISP:  rd_data = disp;
            A_ANDV:  rd_data = and_v;
            A_ANDM:  rd_data = and_v & ~and_m;
            A_SELNZ: rd_data = sel_nz;
            A_SELC:  rd_data = (sel_c == '0) ? sel_z : sel_nz;
            A_SELZ:  rd_data = sel_z;
            A_ADDA:  rd_data = add_a;
            A_ADDB:  rd_data = oc_sum;
            default: rd_data = '0;
        endcase
    end

    // R3
    disp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_we |=> !disp_we);
    // R3
    disp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_DISP) |=> (disp_we && disp == $past(wr_data)));
endmodule

// File: rtl/ttm_seq.sv
module ttm_seq
    import ttm_pkg::*;
#(
    parameter int W = DW,
    parameter int A = AW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rd_data,
    output logic [A-1:0] rd_addr,
    output logic         wr_en,
    output logic [A-1:0] wr_addr,
    output logic [W-1:0] wr_data,
    output logic [A-1:0] pc
);
    localparam int HALF = W / 2;

    phase_t       state, state_nx;
    logic [A-1:0] dst, src, br_tgt;
    logic [W-1:0] data;
    logic         br_pend;
    logic         ign_unused;

    assign ign_unused = ^{rd_data[W-1:HALF+A], rd_data[HALF-1:A]};

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= FETCH_ST;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            FETCH_ST: state_nx = READ_ST;
            READ_ST:  state_nx = WRITE_ST;
            WRITE_ST: state_nx = FETCH_ST;
            default:  state_nx = FETCH_ST;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= A_START; dst <= '0; src <= '0; data <= '0;
            br_pend <= 1'b0; br_tgt <= '0;
        end else begin
            unique case (state)
                FETCH_ST: begin
                    dst     <= rd_data[HALF +: A];
                    src     <= rd_data[0 +: A];
                    pc      <= br_pend ? br_tgt : pc + 1'b1;
                    br_pend <= 1'b0;
                end
                READ_ST:  data <= rd_data;
                WRITE_ST: if (dst == A_PC) begin
                    br_pend <= 1'b1;
                    br_tgt  <= data[A-1:0];
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        rd_addr = (state == FETCH_ST) ? pc : src;
        wr_en   = (state == WRITE_ST);
        wr_addr = dst;
        wr_data = data;
    end

    // R2
    ring_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FETCH_ST) |=> (state == READ_ST));
    // R2
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != FETCH_ST) |=> $stable(pc));
    // R9
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FETCH_ST && !br_pend) |=> (pc == $past(pc) + 1'b1));
    // R8
    br_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_PC) |=> br_pend);
endmodule

// File: rtl/ttm_core.sv
module ttm_core
    import ttm_pkg::*;
#(
    parameter int W = DW,
    parameter int A = AW
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] disp_o,
    output logic         disp_we_o,
    output logic [A-1:0] pc_o
);
    logic [A-1:0] rd_addr, wr_addr, pc;
    logic [W-1:0] rd_data, wr_data, rf_q, unit_q;
    logic         wr_en;

    ttm_seq #(.W(W), .A(A)) seq_i (
        .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pc(pc)
    );

    ttm_regfile #(.W(W), .A(A)) rf_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rf_q)
    );

    ttm_units #(.W(W), .A(A)) units_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(unit_q),
        .disp(disp_o), .disp_we(disp_we_o)
    );

    always_comb begin
        if (rd_addr == A_PC)        rd_data = W'(pc);
        else if (is_unit(rd_addr))  rd_data = unit_q;
        else                        rd_data = rf_q;
    end

    assign pc_o = pc;

    // R1
    reset_pc_chk: assert property (@(posedge clk)
        !rst_n |=> (pc_o == A_START && !disp_we_o && disp_o == '0));
endmodule

// File: tb/ttm_core_tb.sv
module ttm_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] disp_o;
    logic        disp_we_o;
    logic [5:0]  pc_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int t_prev = 0;
    bit done = 1'b0;

    ttm_core dut_i (.clk(clk), .rst_n(rst_n), .disp_o(disp_o),
                    .disp_we_o(disp_we_o), .pc_o(pc_o));

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Wait for the next display strobe, check its value and pulse width
    task automatic expect_disp(input logic [15:0] exp, input string req, output int at);
        int n = 0;
        while (!disp_we_o && n < 400) begin
            @(negedge clk);
            n++;
        end
        at = cyc;
        chk(disp_we_o && disp_o == exp, req, disp_o, exp);
        @(negedge clk);
        chk(!disp_we_o, "R3 strobe width", 32'(disp_we_o), 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(disp_o == 16'h0 && !disp_we_o, "R1 display idle", disp_o, 0);
        chk(pc_o == 6'd1, "R1 start address", pc_o, 1);
        rst_n = 1'b1;
    endtask

    task automatic t_adder();
        int t;
        expect_disp(16'hFFFF, "R5 minus zero kept", t);
        t_prev = t;
        expect_disp(16'h0005, "R4 end-around carry", t);
        chk(t - t_prev == 9, "R2 three-cycle cadence", t - t_prev, 9);
        t_prev = t;
        expect_disp(16'h0003, "R4 accumulate 61 into 61", t);
        chk(t - t_prev == 6, "R2 cadence after accumulate", t - t_prev, 6);
    endtask

    task automatic t_andnot();
        int t;
        expect_disp(16'h8000, "R6 and-not sign isolation", t);
    endtask

    task automatic t_branches();
        int t;
        expect_disp(16'h0063, "R8 delay slot after zero-select branch (R7)", t);
        expect_disp(16'h0005, "R7 nonzero select, R8 delay slot", t);
        expect_disp(16'h0019, "R9 read of counter", t);
        expect_disp(16'h1234, "R10 storage write/read, R2 high bits ignored", t);
        expect_disp(16'h0007, "R8 final delay slot", t);
    endtask

    task automatic t_idle();
        bit extra = 1'b0;
        bit stray = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (disp_we_o) extra = 1'b1;
            if (pc_o != 6'd30 && pc_o != 6'd31) stray = 1'b1;
        end
        chk(!extra, "R8 skipped moves stay silent", 32'(extra), 0);
        chk(!stray, "R9 idle loop counter", pc_o, 30);
    endtask

    initial begin
        t_reset();
        t_adder();
        t_andnot();
        t_branches();
        t_idle();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule